// File: doc/BRIEF.md
# SAR ADC host sequencing controller

This block sits on the host side of an external 14-bit, eight-channel successive-approximation converter and runs its conversion cycle. On a start request it raises the convert strobe and keeps it high for the worst-case conversion time of the chosen supply range. It then drops the strobe and clocks one 14-bit serial frame. During that frame the next configuration word goes out on the data-in line and the finished result comes back on the data-out line, both most significant bit first. Because the converter has no pipeline delay, the word read in a frame belongs to the conversion that has just ended.

The result is handed downstream over a valid/ready handshake. It comes with a 16-bit copy, sign-extended for two's-complement (bipolar) input modes and zero-extended for straight-binary (unipolar) modes, and with the mode flag. The configuration that governs a conversion is the one written in the frame before it. For that reason the mode flag reported with a result is the bipolar selection sent one frame earlier.

After each strobe a cycle timer holds the controller until both the minimum conversion period and the acquisition time have passed. A start request that arrives during a cycle is kept and launched as soon as the timer allows it and the output slot is free. Every time limit is a nanosecond parameter, which is turned into system-clock cycles when the block is elaborated.

Top module: `sar_host_seq`

## Requirements
- R1: After synchronous reset, the convert strobe, serial clock, data-in line and result-valid output are all low.
- R2: Each conversion holds the convert strobe high for exactly ceil(t_conv / clock period) cycles. t_conv is 2200 ns in the high-supply range and 3200 ns in the low-supply range, which gives 440 or 640 cycles at 5 ns.
- R3: Two rising edges of the convert strobe are never closer than max(ceil(4000 ns / period), conversion cycles + ceil(1800 ns / period)) cycles, which is 800 cycles by default. When requests are queued back to back, the spacing is exactly that value.
- R4: The serial clock stays low while the strobe is high. Its first rising edge comes SCK_HALF cycles after the strobe falls. A frame has exactly 14 pulses, and every high phase and every low phase lasts SCK_HALF cycles.
- R5: The configuration word on cfg_word is sampled in the cycle the strobe falls. It is driven out on the data-in line MSB first, and each bit is held stable across the rising edge of the serial clock.
- R6: The data-out line is sampled at each rising edge of the serial clock. The first edge gives result bit 13, and the 14 samples form res_code in arrival order.
- R7: res_bipolar reports the cfg_bipolar value captured in the preceding frame. For the first conversion after reset it is 0 (unipolar).
- R8: res_ext equals res_code zero-extended when res_bipolar is 0 and sign-extended from bit 13 when res_bipolar is 1.
- R9: While res_valid is high and res_ready is low, the result outputs hold steady and no new conversion begins. A conversion may start at the same clock edge that accepts the held result.
- R10: A start request that arrives while a cycle is in progress is kept and launched once R3 and R9 allow it. Each held request gives exactly one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request for one conversion cycle (one-cycle pulse) |
| cfg_word | input | 14 | Configuration word to write in the next frame |
| cfg_bipolar | input | 1 | Marks the configuration in cfg_word as a bipolar input mode |
| adc_cnv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter, idles low |
| adc_din | output | 1 | Serial configuration data to the converter |
| adc_sdo | input | 1 | Serial result data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Downstream accepts the result |
| res_code | output | 14 | Raw 14-bit result |
| res_ext | output | 16 | Result extended to 16 bits according to the mode |
| res_bipolar | output | 1 | Mode of the conversion that produced the result |

## Verification
Two functions can land on the same clock edge: accepting a held result and launching the conversion that was waiting behind it. The bench provokes this by stalling the consumer across one result while a second request is pending. It waits well past the cycle limit, confirms that the strobe stays low and the held result does not change, and then raises ready. It judges that the strobe rises at the very edge that takes the result, with res_valid dropping at that edge. The same run also compares every frame's data-in bits with the configuration queued for it and every result with the value the converter model returned.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_CONVERT  = 2'd1,
      ST_TRANSFER = 2'd2,
      ST_HOLDOFF  = 2'd3
   } seq_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sar_cycle_timer.sv
`timescale 1ns/1ps
module sar_cycle_timer #(
   parameter int CONV_CYC = 440,
   parameter int CYC_MIN  = 800
) (
   input  logic clk,
   input  logic rst,
   input  logic launch,
   output logic conv_done,
   output logic cycle_done
);
   localparam int CW = $clog2(CYC_MIN + 1);
   localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);
   localparam logic [CW-1:0] CYC_LAST  = CW'(CYC_MIN - 1);

   if (CONV_CYC < 1) begin : g_bad_conv
      $error("sar_cycle_timer: CONV_CYC must be at least 1");
   end
   if (CYC_MIN <= CONV_CYC) begin : g_bad_cyc
      $error("sar_cycle_timer: CYC_MIN must exceed CONV_CYC");
   end

   logic [CW-1:0] cnt;

   // counts cycles since the last strobe launch, parks at the limit
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= CYC_LAST;
      end else if (launch) begin
         cnt <= '0;
      end else if (cnt != CYC_LAST) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign conv_done  = (cnt == CONV_LAST);
   assign cycle_done = (cnt == CYC_LAST);

   assert_launch_spacing_R3: assert property (@(posedge clk) disable iff (rst)
      launch |-> cycle_done)
      else $error("launch before minimum cycle time");

   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= CYC_LAST)
      else $error("cycle counter out of range");

endmodule

// File: rtl/sar_serial_frame.sv
`timescale 1ns/1ps
module sar_serial_frame #(
   parameter int W    = 14,
   parameter int HALF = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         go,
   input  logic [W-1:0] tx_word,
   input  logic         sdo,
   output logic         sck,
   output logic         din,
   output logic         done,
   output logic [W-1:0] rx_word
);
   localparam int HW = $clog2(HALF + 1);
   localparam int BW = $clog2(W + 1);
   localparam logic [HW-1:0] HALF_LAST = HW'(HALF - 1);
   localparam logic [BW-1:0] BIT_LAST  = BW'(W - 1);

   if (W < 2) begin : g_bad_w
      $error("sar_serial_frame: W must be at least 2");
   end
   if (HALF < 1) begin : g_bad_half
      $error("sar_serial_frame: HALF must be at least 1");
   end

   logic          active;
   logic [HW-1:0] hc;
   logic [BW-1:0] bitn;
   logic [W-1:0]  tx_sh;
   logic [W-1:0]  rx_sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         hc     <= '0;
         bitn   <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         sck    <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            active <= 1'b1;
            hc     <= '0;
            bitn   <= '0;
            tx_sh  <= tx_word;
            sck    <= 1'b0;
         end else if (active) begin
            if (hc == HALF_LAST) begin
               hc <= '0;
               if (!sck) begin
                  // rising edge: previous falling edge let the slave settle
                  sck   <= 1'b1;
                  rx_sh <= {rx_sh[W-2:0], sdo};
               end else begin
                  sck <= 1'b0;
                  if (bitn == BIT_LAST) begin
                     active <= 1'b0;
                     done   <= 1'b1;
                     tx_sh  <= '0;
                  end else begin
                     bitn  <= bitn + 1'b1;
                     tx_sh <= {tx_sh[W-2:0], 1'b0};
                  end
               end
            end else begin
               hc <= hc + 1'b1;
            end
         end
      end
   end

   assign din     = tx_sh[W-1];
   assign rx_word = rx_sh;

   assert_sck_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
      sck |-> active)
      else $error("serial clock high outside a frame");

   assert_din_hold_R5: assert property (@(posedge clk) disable iff (rst)
      sck |-> $stable(din))
      else $error("data-in changed while serial clock high");

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      done |=> !done)
      else $error("frame done longer than one cycle");

endmodule

// File: rtl/sar_result_fmt.sv
`timescale 1ns/1ps
module sar_result_fmt #(
   parameter int W     = 14,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [W-1:0]     code_in,
   input  logic             bip_in,
   input  logic             ready,
   output logic             valid,
   output logic [W-1:0]     code,
   output logic [OUT_W-1:0] ext,
   output logic             bip
);
   if (OUT_W < W) begin : g_bad_out
      $error("sar_result_fmt: OUT_W must not be below W");
   end

   logic [OUT_W-1:0] ext_d;

   if (OUT_W == W) begin : g_same
      assign ext_d = code_in;
   end else begin : g_ext
      logic fill;
      assign fill  = bip_in & code_in[W-1];
      assign ext_d = {{(OUT_W - W){fill}}, code_in};

      assert_unipolar_zero_R8: assert property (@(posedge clk) disable iff (rst)
         (valid && !bip) |-> (ext[OUT_W-1:W] == '0))
         else $error("unipolar result has nonzero upper bits");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         code  <= '0;
         ext   <= '0;
         bip   <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         code  <= code_in;
         ext   <= ext_d;
         bip   <= bip_in;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (valid && !ready) |=> (valid && $stable(code) && $stable(ext) && $stable(bip)))
      else $error("held result changed");

   assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
      load |-> (!valid || ready))
      else $error("result overwritten before acceptance");

endmodule

// File: rtl/sar_host_seq.sv
`timescale 1ns/1ps
module sar_host_seq
   import sar_seq_pkg::*;
#(
   parameter int CLK_NS      = 5,
   parameter bit LOW_SUPPLY  = 1'b0,
   parameter int TCONV_HI_NS = 2200,
   parameter int TCONV_LO_NS = 3200,
   parameter int TCYC_NS     = 4000,
   parameter int TACQ_NS     = 1800,
   parameter int SCK_HALF    = 2,
   parameter int WORD_W      = 14,
   parameter int OUT_W       = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_req,
   input  logic [WORD_W-1:0] cfg_word,
   input  logic              cfg_bipolar,
   output logic              adc_cnv,
   output logic              adc_sck,
   output logic              adc_din,
   input  logic              adc_sdo,
   output logic              res_valid,
   input  logic              res_ready,
   output logic [WORD_W-1:0] res_code,
   output logic [OUT_W-1:0]  res_ext,
   output logic              res_bipolar
);
   localparam int TCONV_NS = LOW_SUPPLY ? TCONV_LO_NS : TCONV_HI_NS;
   localparam int CONV_CYC = ceil_div(TCONV_NS, CLK_NS);
   localparam int CYC_MIN  = imax(ceil_div(TCYC_NS, CLK_NS),
                                  CONV_CYC + ceil_div(TACQ_NS, CLK_NS));

   if (SCK_HALF * CLK_NS < 10) begin : g_bad_sck
      $error("sar_host_seq: SCK_HALF phases shorter than 10 ns");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sar_host_seq: CLK_NS must be positive");
   end

   seq_state_t        state;
   logic              pend;
   logic              mode_next;
   logic              mode_cur;
   logic              conv_done;
   logic              cycle_done;
   logic              frame_done;
   logic [WORD_W-1:0] rx_word;
   logic              want;
   logic              slot_free;
   logic              launch;
   logic              go;
   logic              load;

   assign want      = pend | start_req;
   assign slot_free = !res_valid || res_ready;
   assign launch    = ((state == ST_IDLE) || (state == ST_HOLDOFF)) &&
                      cycle_done && want && slot_free;
   assign go        = (state == ST_CONVERT) && conv_done;
   assign load      = (state == ST_TRANSFER) && frame_done;

   sar_cycle_timer #(
      .CONV_CYC (CONV_CYC),
      .CYC_MIN  (CYC_MIN)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .launch     (launch),
      .conv_done  (conv_done),
      .cycle_done (cycle_done)
   );

   sar_serial_frame #(
      .W    (WORD_W),
      .HALF (SCK_HALF)
   ) u_frame (
      .clk     (clk),
      .rst     (rst),
      .go      (go),
      .tx_word (cfg_word),
      .sdo     (adc_sdo),
      .sck     (adc_sck),
      .din     (adc_din),
      .done    (frame_done),
      .rx_word (rx_word)
   );

   sar_result_fmt #(
      .W     (WORD_W),
      .OUT_W (OUT_W)
   ) u_fmt (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .code_in (rx_word),
      .bip_in  (mode_cur),
      .ready   (res_ready),
      .valid   (res_valid),
      .code    (res_code),
      .ext     (res_ext),
      .bip     (res_bipolar)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         adc_cnv   <= 1'b0;
         pend      <= 1'b0;
         mode_next <= 1'b0;
         mode_cur  <= 1'b0;
      end else begin
         pend <= launch ? 1'b0 : want;
         case (state)
            ST_IDLE: begin
               if (launch) begin
                  state   <= ST_CONVERT;
                  adc_cnv <= 1'b1;
               end
            end
            ST_CONVERT: begin
               if (go) begin
                  state     <= ST_TRANSFER;
                  adc_cnv   <= 1'b0;
                  // this conversion ran under the word from the previous frame
                  mode_cur  <= mode_next;
                  mode_next <= cfg_bipolar;
               end
            end
            ST_TRANSFER: begin
               if (frame_done) begin
                  state <= ST_HOLDOFF;
               end
            end
            ST_HOLDOFF: begin
               if (launch) begin
                  state   <= ST_CONVERT;
                  adc_cnv <= 1'b1;
               end else if (cycle_done) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_sck_idle_conv_R4: assert property (@(posedge clk) disable iff (rst)
      adc_cnv |-> !adc_sck)
      else $error("serial clock high during conversion");

   assert_cnv_width_R2: assert property (@(posedge clk) disable iff (rst)
      $fell(adc_cnv) |-> $past(conv_done))
      else $error("strobe dropped before conversion time");

   assert_no_launch_full_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(adc_cnv) |-> $past(!res_valid || res_ready))
      else $error("conversion started with result slot full");

   assert_hold_request_R10: assert property (@(posedge clk) disable iff (rst)
      ((state == ST_TRANSFER) && start_req) |=> pend)
      else $error("start request during transfer lost");

endmodule

// File: tb/sim_sar_host_seq.sv
`timescale 1ns/1ps
module sim_sar_host_seq;
   localparam int CLK_NS = 5;
   localparam int H      = 2;
   localparam int CONV   = 2200 / CLK_NS;
   localparam int CYCMIN = ((4000 / CLK_NS) > (CONV + 1800 / CLK_NS)) ?
                           (4000 / CLK_NS) : (CONV + 1800 / CLK_NS);

   logic        clk = 1'b0;
   logic        rst;
   logic        start_req;
   logic [13:0] cfg_word;
   logic        cfg_bipolar;
   logic        adc_cnv, adc_sck, adc_din, adc_sdo;
   logic        res_valid, res_ready, res_bipolar;
   logic [13:0] res_code;
   logic [15:0] res_ext;

   always #2.5 clk = ~clk;

   sar_host_seq #(.CLK_NS(CLK_NS), .SCK_HALF(H)) u0 (
      .clk(clk), .rst(rst), .start_req(start_req), .cfg_word(cfg_word),
      .cfg_bipolar(cfg_bipolar), .adc_cnv(adc_cnv), .adc_sck(adc_sck),
      .adc_din(adc_din), .adc_sdo(adc_sdo), .res_valid(res_valid),
      .res_ready(res_ready), .res_code(res_code), .res_ext(res_ext),
      .res_bipolar(res_bipolar)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   typedef struct {
      logic [13:0] code;
      logic [15:0] ext;
      logic        bip;
   } exp_t;

   exp_t        exp_q[$];
   logic [13:0] code_q[$];
   logic [13:0] cfg_q[$];
   bit          prev_bip = 1'b0;
   int          issued = 0;

   // converter model: loads its result at the strobe, next bit after each fall
   logic [13:0] mdl_sh = '0;
   always @(posedge adc_cnv or negedge adc_sck) begin
      if (adc_cnv) begin
         if (code_q.size() != 0) mdl_sh <= code_q.pop_front();
      end else begin
         mdl_sh <= {mdl_sh[12:0], 1'b0};
      end
   end
   assign adc_sdo = mdl_sh[13];

   // capture of the data-in line at each serial clock rise
   logic [13:0] din_sh = '0;
   int          din_tot = 0;
   always @(posedge adc_sck) begin
      din_sh  = {din_sh[12:0], adc_din};
      din_tot = din_tot + 1;
   end

   // monitor: timing of strobe and serial clock, frame contents, results
   bit prev_cnv = 0, prev_sck = 0, have_rise = 0, frame_open = 0;
   bit gap_armed = 0, bad_w = 0, final_close = 0;
   int cyc = 0, last_rise = 0, min_int = 1000000, rises = 0;
   int hi_cnt = 0, gap = 0, ph_cnt = 0, din_base = 0;

   task automatic frame_close();
      if (frame_open) begin
         check((din_tot - din_base) == 14, "R4", "sck pulses per frame", din_tot - din_base, 14);
         check(bad_w == 0, "R4", "sck phase widths", int'(bad_w), 0);
         if (cfg_q.size() != 0) begin
            logic [13:0] e;
            e = cfg_q.pop_front();
            check(din_sh == e, "R5", "config word on data-in", int'(din_sh), int'(e));
         end else begin
            check(1'b0, "R5", "config queue empty", 0, 1);
         end
      end
      frame_open = 0;
      din_base   = din_tot;
      bad_w      = 0;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         if (adc_cnv && !prev_cnv) begin
            if (have_rise) begin
               check((cyc - last_rise) >= CYCMIN, "R3", "strobe spacing",
                     cyc - last_rise, CYCMIN);
               if ((cyc - last_rise) < min_int) min_int = cyc - last_rise;
            end
            have_rise = 1;
            last_rise = cyc;
            rises++;
            hi_cnt = 0;
            frame_close();
         end
         if (adc_cnv) hi_cnt++;
         if (!adc_cnv && prev_cnv) begin
            check(hi_cnt == CONV, "R2", "strobe high cycles", hi_cnt, CONV);
            gap = 0;
            gap_armed = 1;
            frame_open = 1;
         end
         if (adc_cnv && adc_sck) bad_w = 1;
         if (gap_armed && !adc_sck) gap++;
         if (adc_sck != prev_sck) begin
            if (adc_sck && gap_armed) begin
               check(gap == H, "R4", "strobe fall to first sck rise", gap, H);
               gap_armed = 0;
            end else if (ph_cnt != H) begin
               bad_w = 1;
            end
            ph_cnt = 1;
         end else begin
            ph_cnt++;
         end
         if (final_close) begin
            frame_close();
            final_close = 0;
         end
         if (res_valid && res_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", "unexpected result", int'(res_code), 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(res_code == e.code, "R6", "result code", int'(res_code), int'(e.code));
               check(res_bipolar == e.bip, "R7", "mode flag", int'(res_bipolar), int'(e.bip));
               check(res_ext == e.ext, "R8", "extended result", int'(res_ext), int'(e.ext));
            end
         end
      end
      prev_cnv = adc_cnv;
      prev_sck = adc_sck;
   end

   // driver: queues expectations and pulses a start request
   task automatic issue(input logic [13:0] code, input logic [13:0] cfg, input logic bip);
      exp_t e;
      e.code = code;
      e.bip  = prev_bip;
      e.ext  = prev_bip ? {{2{code[13]}}, code} : {2'b00, code};
      prev_bip = bip;
      code_q.push_back(code);
      cfg_q.push_back(cfg);
      exp_q.push_back(e);
      issued++;
      @(posedge clk); #1;
      cfg_word    = cfg;
      cfg_bipolar = bip;
      start_req   = 1'b1;
      @(posedge clk); #1;
      start_req   = 1'b0;
   endtask

   task automatic wait_frame();
      @(negedge adc_cnv);
      @(posedge clk);
   endtask

   logic [13:0] codes [6] = '{14'h0000, 14'h3FFF, 14'h2000, 14'h1FFF, 14'h3FFF, 14'h2ABC};
   logic [13:0] cfgs  [6] = '{14'h3C01, 14'h2AAA, 14'h1555, 14'h3FFF, 14'h0000, 14'h0F0F};
   logic        bips  [6] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

   initial begin
      rst = 1'b1; start_req = 1'b0; cfg_word = '0; cfg_bipolar = 1'b0; res_ready = 1'b1;
      repeat (3) @(negedge clk);
      check(adc_cnv == 0 && adc_sck == 0 && adc_din == 0, "R1", "serial pins in reset",
            int'({adc_cnv, adc_sck, adc_din}), 0);
      check(res_valid == 0, "R1", "valid in reset", int'(res_valid), 0);
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      check(adc_cnv == 0 && adc_sck == 0 && res_valid == 0, "R1", "idle after reset",
            int'({adc_cnv, adc_sck, res_valid}), 0);

      // back-to-back conversions, each next request held during the transfer (R10)
      for (int i = 0; i < 6; i++) begin
         issue(codes[i], cfgs[i], bips[i]);
         wait_frame();
      end
      wait (exp_q.size() == 0);

      // consumer stall: held result and launch colliding with acceptance (R9)
      @(posedge clk); #1 res_ready = 1'b0;
      issue(14'h1234, 14'h3333, 1'b1);
      wait_frame();
      issue(14'h3001, 14'h0CCC, 1'b0);
      while (!res_valid) @(negedge clk);
      repeat (CYCMIN) @(negedge clk);
      check(adc_cnv == 0, "R9", "no launch while result held", int'(adc_cnv), 0);
      check(res_code == 14'h1234 && res_valid, "R9", "held result", int'(res_code), 'h1234);
      @(posedge clk); #1 res_ready = 1'b1;
      @(negedge clk);
      check(adc_cnv == 0, "R9", "strobe before accept edge", int'(adc_cnv), 0);
      @(negedge clk);
      check(adc_cnv == 1, "R9", "launch at accept edge", int'(adc_cnv), 1);
      check(res_valid == 0, "R9", "valid cleared at accept", int'(res_valid), 0);
      wait_frame();
      wait (exp_q.size() == 0);
      repeat (50) @(negedge clk);
      final_close = 1;
      repeat (2) @(negedge clk);

      check(min_int == CYCMIN, "R3", "back-to-back spacing", min_int, CYCMIN);
      check(rises == issued, "R10", "one conversion per request", rises, issued);
      check(exp_q.size() == 0, "R6", "all results delivered", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule